// File: doc/BRIEF.md
# Line-Locked Boost Clock Divider

This block produces the switching clock for a boost converter by dividing a reference clock by a programmable power of two. A line counter runs inside the block and counts reference clocks across one display line. Every time that counter wraps to zero, the divided clock is forced back to the start of its period. Because the switching edges then sit at the same place in every line, they cannot drift against the line rate and cause visible flicker.

A 3-bit code selects the divide ratio. A 5-bit value sets the number of reference clocks in one line. The block outputs the divided clock, a one-cycle marker for the first clock of each line, and the current position inside the line. If the divided period is longer than a line, the line boundary cuts each period short, and the high and low times are no longer equal.

Top module: `line_sync_boost_div`

## Requirements
- R1: While `rst` is sampled high at a rising edge, the next state is `line_pos` = 0, `boost_clk` = 0 and `line_start` = 1.
- R2: `line_pos` increases by one on each rising edge. The edge that finds it at or above L-1 loads 0, where L is the effective line length. This also holds when L shrinks in the middle of a line.
- R3: The effective line length L equals `line_len`. A `line_len` of 0 or 1 is treated as 2.
- R4: `line_start` is 1 exactly in the cycles where `line_pos` is 0.
- R5: For a code c in 2..7 the ratio is 1/2^(c-1). `boost_clk` is 1 when bit c-2 of the in-line count is 0, so each full period is high for its first half and low for its second half. Example: code 4 gives 4 cycles high then 4 cycles low. `boost_clk` is registered and loaded at the same edge as `line_pos`, using the code sampled at that edge.
- R6: With a valid code, `boost_clk` is 1 in every cycle where `line_start` is 1. The period always restarts at the line boundary, whatever point it had reached.
- R7: When the divided period is longer than a line, the line boundary cuts the last period short. With code 6 and a 25-clock line, the clock is high for 16 cycles and low for 9. With code 7 and a line of at most 31 clocks, it stays high for the whole line.
- R8: Division code 0 holds `boost_clk` at 0.
- R9: Division code 1 behaves exactly like code 2 (1/2), the fastest ratio a registered output can produce.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| div_code | input | 3 | Division code |
| line_len | input | 5 | Reference clocks per line |
| boost_clk | output | 1 | Divided, line-locked boost clock |
| line_start | output | 1 | High on the first clock of each line |
| line_pos | output | 5 | Reference clock count inside the line |

## Verification
The properties assume that the effective line length is at least 2. They also assume that the code and length seen at an edge are the values that edge acts on. The line-start property therefore disregards the first cycle after reset, because the outputs still hold their reset values in that cycle.

The stimulus changes inputs only on falling edges. It covers every code from 0 to 7, and line lengths of 0, 1, 2, 8, 25 and 31. It shortens a line while the counter is already past the new end, and it applies reset in the middle of a run. The scoreboard model derives each expected count and clock level from the requirements alone.

// File: rtl/line_sync_boost_div.sv
module line_sync_boost_div #(
  parameter int POS_W  = 5,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] div_code,
  input  logic [POS_W-1:0]  line_len,
  output logic              boost_clk,
  output logic              line_start,
  output logic [POS_W-1:0]  line_pos
);
  localparam int TAP_W = ((1 << CODE_W) > POS_W) ? (1 << CODE_W) : POS_W;

  logic [POS_W-1:0]  span, pos_nx;
  logic [CODE_W-1:0] sel;
  logic [TAP_W-1:0]  tap;

  assign span   = (line_len < POS_W'(2)) ? POS_W'(2) : line_len;
  assign pos_nx = (line_pos >= span - POS_W'(1)) ? '0 : line_pos + POS_W'(1);
  assign sel    = (div_code <= CODE_W'(1)) ? '0 : div_code - CODE_W'(2);
  assign tap    = TAP_W'(pos_nx);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_pos  <= '0;
      boost_clk <= 1'b0;
    end else begin
      line_pos  <= pos_nx;
      boost_clk <= (div_code != '0) && !tap[sel];
    end
  end

  assign line_start = (line_pos == '0);
endmodule

module boost_div_chk #(
  parameter int POS_W  = 5,
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] div_code,
  input logic              boost_clk,
  input logic              line_start,
  input logic [POS_W-1:0]  line_pos
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (line_pos == '0 && !boost_clk));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (line_pos != '0) |-> (line_pos == $past(line_pos) + POS_W'(1)));

  // R4
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    line_start |=> !line_start);

  // R6
  phase_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (line_start && !$past(rst) && $past(div_code) != '0) |-> boost_clk);

  // R8
  code_off_chk: assert property (@(posedge clk) disable iff (rst)
    (div_code == '0) |=> !boost_clk);
endmodule

bind line_sync_boost_div boost_div_chk #(.POS_W(POS_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .div_code(div_code), .boost_clk(boost_clk),
  .line_start(line_start), .line_pos(line_pos)
);

// File: tb/test_line_sync_boost_div.sv
module test_line_sync_boost_div;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  typedef struct packed {
    logic [4:0] pos;
    logic       boost;
    logic       start;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] div_code = 3'd4;
  logic [4:0] line_len = 5'd25;
  logic       boost_clk, line_start;
  logic [4:0] line_pos;

  exp_t  exp_q[$];
  int    n_chk = 0, n_err = 0, cycles = 0;
  int    mpos = 0;
  string tag = "R1";

  line_sync_boost_div i_line_sync_boost_div (
    .clk(clk), .rst(rst), .div_code(div_code), .line_len(line_len),
    .boost_clk(boost_clk), .line_start(line_start), .line_pos(line_pos)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model: pushes what each edge must produce
  always @(posedge clk) begin
    exp_t e;
    int   len, k;
    if (rst) begin
      mpos = 0;
      e = '{pos: 5'd0, boost: 1'b0, start: 1'b1};
    end else begin
      len  = (line_len < 2) ? 2 : int'(line_len);
      mpos = (mpos >= len - 1) ? 0 : mpos + 1;
      k    = (div_code <= 1) ? 0 : int'(div_code) - 2;
      e.pos   = 5'(mpos);
      e.boost = (div_code != 0) && (((mpos >> k) & 1) == 0);
      e.start = (mpos == 0);
    end
    exp_q.push_back(e);
  end

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    exp_t e;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      n_chk++;
      if (line_pos !== e.pos || boost_clk !== e.boost || line_start !== e.start) begin
        n_err++;
        $display("FAIL %s: pos/boost/start actual %0d/%b/%b expected %0d/%b/%b",
                 tag, line_pos, boost_clk, line_start, e.pos, e.boost, e.start);
      end
    end
  end

  task automatic drive(input string t, input logic [2:0] c, input logic [4:0] l, input int n);
    @(negedge clk);
    tag = t; div_code = c; line_len = l;
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    tag = "R1 reset";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    drive("R5 code4 /8 line25, R4 start", 3'd4, 5'd25, 80);
    drive("R5 code5 /16 line25, R6 restart", 3'd5, 5'd25, 80);
    drive("R7 code6 /32 truncated line25", 3'd6, 5'd25, 80);
    drive("R7 code7 /64 whole line high", 3'd7, 5'd25, 60);
    drive("R5 code2 /2 line31, R2 wrap", 3'd2, 5'd31, 70);
    drive("R5 code3 /4 line31", 3'd3, 5'd31, 20);
    drive("R2 shrink mid-line to 8", 3'd3, 5'd8, 40);
    drive("R9 code1 as /2", 3'd1, 5'd8, 30);
    drive("R8 code0 held low", 3'd0, 5'd25, 60);
    drive("R3 len0 clamp 2", 3'd2, 5'd0, 12);
    drive("R3 len1 clamp 2", 3'd3, 5'd1, 12);
    drive("R3 len2", 3'd4, 5'd2, 12);
    drive("R6 code4 odd line 11", 3'd4, 5'd11, 50);
    @(negedge clk); tag = "R1 mid-run reset"; rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    drive("R5 after reset code4 line25", 3'd4, 5'd25, 40);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule